// File: doc/BRIEF.md
# Dual-Port Line Interface Mode Decoder

This block turns the control word of a dual-port subscriber line interface into the settings the analog side needs. The word has three mode bits, two port-select bits and a thermal alarm. The block produces the operating mode of the shared line core and a four-way termination choice for each of the two line ports. It also drives three open-drain supervision outputs: one summary detector and one detector per line. Each is modelled as an output enable with a constant low data value. Three raw detector inputs are routed to these outputs or masked, depending on the mode and on which ports are selected.

A small state machine handles thermal overload. While the synchronised alarm is high, the block sits in state `ST_SHUT`. It forces the core off, opens both ports and disables every detector output. The transition `ST_SHUT -> ST_RUN` is taken on the first clock where the synchronised alarm is low. From then on, the outputs again follow the command word currently applied, which is the last one commanded. The transition `ST_RUN -> ST_SHUT` is taken on the first clock where the synchronised alarm is high. All outputs are registered on the system clock, so changes on the control inputs cannot glitch them.

Top module: `line_mode_decoder`

## Requirements
- R1: `core_mode` decodes `ctl_mode` (bit0 = A, bit1 = B, bit2 = C) one clock after it is applied:
  - A=0, B=0 gives 0 (off), whatever C is.
  - A=0, B=1 gives 1 (active, forward) when C=0 and 2 (active, reversed) when C=1.
  - A=1, B=1 gives 3 (active with metering, forward) when C=0 and 4 (active with metering, reversed) when C=1.
- R2: In off mode, a port whose `port_sel` bit is 0 is open. Its termination code is 0 (codes: 0 open, 1 resistor-fed, 2 on core driver, 3 current-source bias; port i uses `port_term[2i+1:2i]`). Its line detector enable is 0.
- R3: In off mode, a port whose `port_sel` bit is 1 is resistor-fed (code 1). Its `line_det_oe` bit equals that port's `hook_line` bit as sampled one clock earlier.
- R4: In off mode, `sum_det_oe` is the OR of the two `line_det_oe` bits.
- R5: In every mode other than off, a selected port gets code 2 and an unselected port gets code 3. Both `line_det_oe` bits are 0, and `sum_det_oe` equals `hook_core` sampled one clock earlier when at least one port is selected.
- R6: In a mode other than off with both `port_sel` bits 0, `sum_det_oe` stays 0 whatever `hook_core` does.
- R7: After `therm_alarm` rises, the outputs are forced on the third rising clock edge: `core_mode` 0, both ports open, all three enables 0. This holds regardless of the other inputs while the alarm stays high.
- R8: After `therm_alarm` falls, the outputs again show the decode of the current command on the third rising clock edge.
- R9: While `rst_n` is low, `core_mode` is 0, both ports are open and all enables are 0.
- R10: A=1, B=0 is ring mode. `core_mode` is 5 when C=0 and 6 when C=1, so a toggling C bit shows as alternating ring phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_mode | input | 3 | Mode bits A (bit0), B (bit1), C (bit2) |
| port_sel | input | N_PORTS | Port select, bit i for line port i |
| therm_alarm | input | 1 | Asynchronous thermal overload alarm |
| hook_core | input | 1 | Raw core supervision detector (1 = event) |
| hook_line | input | N_PORTS | Raw per-line resistor-feed detectors (1 = event) |
| core_mode | output | 3 | Registered core operating mode code |
| port_term | output | 2*N_PORTS | Registered termination code per port |
| sum_det_oe | output | 1 | Summary detector open-drain enable (1 = pin pulled low) |
| line_det_oe | output | N_PORTS | Per-line detector open-drain enables |

## Verification
Random control words, port selections and detector levels cover all eight mode codes crossed with all four port selections. This separates the off-mode routing (per-line detectors, OR into the summary) from the core-driven routing (summary from the core detector only). Directed cases toggle one detector at a time, so a swapped line or a missing mask shows up, and they toggle the C bit in ring mode to check the ring phases. Thermal sequences change the command while the alarm is held, then check the edge on which the override takes effect and the edge on which the newly commanded state appears. This tells a correct synchroniser depth apart from a missing or doubled stage.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    typedef enum logic [2:0] {
        CM_OFF      = 3'd0,
        CM_FWD      = 3'd1,
        CM_REV      = 3'd2,
        CM_MTR_FWD  = 3'd3,
        CM_MTR_REV  = 3'd4,
        CM_RING_FWD = 3'd5,
        CM_RING_REV = 3'd6
    } core_mode_e;

    typedef enum logic [1:0] {
        TM_OPEN    = 2'd0,
        TM_RESFEED = 2'd1,
        TM_DRIVER  = 2'd2,
        TM_BIAS    = 2'd3
    } term_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SHUT = 1'b1
    } therm_state_e;

endpackage

// File: rtl/lmd_therm_sync.sv
module lmd_therm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lmd_core_decode.sv
module lmd_core_decode
    import lmd_pkg::*;
(
    input  logic [2:0]  ctl,
    output core_mode_e  mode
);
    always_comb begin
        unique case ({ctl[1], ctl[0]})
            2'b00: mode = CM_OFF;
            2'b10: mode = ctl[2] ? CM_REV      : CM_FWD;
            2'b11: mode = ctl[2] ? CM_MTR_REV  : CM_MTR_FWD;
            2'b01: mode = ctl[2] ? CM_RING_REV : CM_RING_FWD;
            default: mode = CM_OFF;
        endcase
    end
endmodule

// File: rtl/lmd_port_map.sv
module lmd_port_map
    import lmd_pkg::*;
#(
    parameter int N_PORTS = 2
) (
    input  core_mode_e           mode,
    input  logic [N_PORTS-1:0]   port_sel,
    input  logic                 hook_core,
    input  logic [N_PORTS-1:0]   hook_line,
    output logic [2*N_PORTS-1:0] term_flat,
    output logic [N_PORTS-1:0]   line_oe,
    output logic                 sum_oe
);
    logic core_off;
    assign core_off = (mode == CM_OFF);

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            term_e t;
            always_comb begin
                if (core_off) begin
                    t             = port_sel[p] ? TM_RESFEED : TM_OPEN;
                    line_oe[p]    = port_sel[p] & hook_line[p];
                end else begin
                    t             = port_sel[p] ? TM_DRIVER : TM_BIAS;
                    line_oe[p]    = 1'b0;
                end
            end
            assign term_flat[2*p +: 2] = t;
        end
    endgenerate

    always_comb begin
        if (core_off) sum_oe = |line_oe;
        else          sum_oe = hook_core & (|port_sel);
    end
endmodule

// File: rtl/line_mode_decoder.sv
module line_mode_decoder
    import lmd_pkg::*;
#(
    parameter int N_PORTS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           ctl_mode,
    input  logic [N_PORTS-1:0]   port_sel,
    input  logic                 therm_alarm,
    input  logic                 hook_core,
    input  logic [N_PORTS-1:0]   hook_line,
    output logic [2:0]           core_mode,
    output logic [2*N_PORTS-1:0] port_term,
    output logic                 sum_det_oe,
    output logic [N_PORTS-1:0]   line_det_oe
);
    localparam int TERM_W = 2 * N_PORTS;

    logic                alarm_s;
    therm_state_e        st_q, st_nxt;
    core_mode_e          dec_mode;
    logic [TERM_W-1:0]   dec_term;
    logic [N_PORTS-1:0]  dec_line_oe;
    logic                dec_sum_oe;

    lmd_therm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (therm_alarm),
        .dout  (alarm_s)
    );

    lmd_core_decode u_dec (
        .ctl  (ctl_mode),
        .mode (dec_mode)
    );

    lmd_port_map #(.N_PORTS(N_PORTS)) u_map (
        .mode      (dec_mode),
        .port_sel  (port_sel),
        .hook_core (hook_core),
        .hook_line (hook_line),
        .term_flat (dec_term),
        .line_oe   (dec_line_oe),
        .sum_oe    (dec_sum_oe)
    );

    // Thermal override state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_nxt;
    end

    always_comb begin
        unique case (st_q)
            ST_RUN:  st_nxt = alarm_s ? ST_SHUT : ST_RUN;
            ST_SHUT: st_nxt = alarm_s ? ST_SHUT : ST_RUN;
            default: st_nxt = ST_RUN;
        endcase
    end

    // Registered outputs, forced while the next state is the shutdown state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_mode   <= CM_OFF;
            port_term   <= '0;
            sum_det_oe  <= 1'b0;
            line_det_oe <= '0;
        end else begin
            unique case (st_nxt)
                ST_SHUT: begin
                    core_mode   <= CM_OFF;
                    port_term   <= '0;
                    sum_det_oe  <= 1'b0;
                    line_det_oe <= '0;
                end
                default: begin
                    core_mode   <= dec_mode;
                    port_term   <= dec_term;
                    sum_det_oe  <= dec_sum_oe;
                    line_det_oe <= dec_line_oe;
                end
            endcase
        end
    end
endmodule

// File: rtl/lmd_checker.sv
module lmd_checker
    import lmd_pkg::*;
#(
    parameter int N_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alarm_s,
    input therm_state_e         st_q,
    input logic [2:0]           core_mode,
    input logic [2*N_PORTS-1:0] port_term,
    input logic                 sum_det_oe,
    input logic [N_PORTS-1:0]   line_det_oe
);
    assert_pd_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_mode == CM_OFF) |-> (sum_det_oe == (|line_det_oe)));

    assert_core_masks_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_mode != CM_OFF) |-> (line_det_oe == '0));

    assert_no_port_no_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_mode != CM_OFF) && (port_term == {N_PORTS{TM_BIAS}})) |-> !sum_det_oe);

    assert_shut_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHUT) |-> (core_mode == CM_OFF && port_term == '0
                               && !sum_det_oe && line_det_oe == '0));

    assert_alarm_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_s |=> (st_q == ST_SHUT));

    assert_alarm_leaves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SHUT) && !alarm_s) |=> (st_q == ST_RUN));

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_mode != 3'd7);

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
            assert_line_needs_feed_R3: assert property (@(posedge clk) disable iff (!rst_n)
                line_det_oe[p] |-> (port_term[2*p +: 2] == TM_RESFEED));
            assert_off_terms_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (core_mode == CM_OFF) |-> (port_term[2*p +: 2] == TM_OPEN
                                         || port_term[2*p +: 2] == TM_RESFEED));
        end
    endgenerate
endmodule

bind line_mode_decoder lmd_checker #(.N_PORTS(N_PORTS)) u_lmd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alarm_s     (alarm_s),
    .st_q        (st_q),
    .core_mode   (core_mode),
    .port_term   (port_term),
    .sum_det_oe  (sum_det_oe),
    .line_det_oe (line_det_oe)
);

// File: tb/test_line_mode_decoder.sv
module test_line_mode_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ctl_mode = '0;
    logic [1:0] port_sel = '0;
    logic       therm_alarm = 1'b0;
    logic       hook_core = 1'b0;
    logic [1:0] hook_line = '0;
    logic [2:0] core_mode;
    logic [3:0] port_term;
    logic       sum_det_oe;
    logic [1:0] line_det_oe;

    int checks = 0;
    int errors = 0;
    logic hot = 1'b0;   // expected override state

    always #2 clk = ~clk;   // 250 MHz

    line_mode_decoder i_line_mode_decoder (
        .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .port_sel(port_sel),
        .therm_alarm(therm_alarm), .hook_core(hook_core), .hook_line(hook_line),
        .core_mode(core_mode), .port_term(port_term),
        .sum_det_oe(sum_det_oe), .line_det_oe(line_det_oe)
    );

    function automatic logic [2:0] exp_mode(input logic [2:0] c, input logic h);
        if (h) return 3'd0;
        case ({c[1], c[0]})
            2'b00:   return 3'd0;
            2'b10:   return c[2] ? 3'd2 : 3'd1;
            2'b11:   return c[2] ? 3'd4 : 3'd3;
            default: return c[2] ? 3'd6 : 3'd5;
        endcase
    endfunction

    // {term[3:0], sum, line[1:0]}
    function automatic logic [6:0] exp_rest(input logic [2:0] c, input logic [1:0] ps,
                                            input logic hc, input logic [1:0] hl,
                                            input logic h);
        logic [3:0] t;
        logic [1:0] l;
        logic s;
        if (h) return 7'd0;
        if (exp_mode(c, 1'b0) == 3'd0) begin
            for (int i = 0; i < 2; i++) begin
                t[2*i +: 2] = ps[i] ? 2'd1 : 2'd0;
                l[i] = ps[i] & hl[i];
            end
            s = |l;
        end else begin
            for (int i = 0; i < 2; i++) t[2*i +: 2] = ps[i] ? 2'd2 : 2'd3;
            l = 2'b00;
            s = hc & (|ps);
        end
        return {t, s, l};
    endfunction

    function automatic string rest_tag(input logic [2:0] c, input logic [1:0] ps, input logic h);
        if (h) return "R7";
        if (exp_mode(c, 1'b0) == 3'd0) return (ps == 2'b00) ? "R2" : "R3,R4";
        return (ps == 2'b00) ? "R6" : "R5";
    endfunction

    task automatic check_all(input string note);
        logic [2:0] em;
        logic [6:0] er;
        logic [6:0] ar;
        string mt;
        em = exp_mode(ctl_mode, hot);
        er = exp_rest(ctl_mode, port_sel, hook_core, hook_line, hot);
        ar = {port_term, sum_det_oe, line_det_oe};
        mt = hot ? "R7" : (ctl_mode[1:0] == 2'b01 ? "R10" : "R1");
        checks++;
        if (core_mode !== em) begin
            errors++;
            $display("FAIL %s %s core_mode actual=%0d expected=%0d", mt, note, core_mode, em);
        end
        checks++;
        if (ar !== er) begin
            errors++;
            $display("FAIL %s %s term/sum/line actual=%b expected=%b",
                     rest_tag(ctl_mode, port_sel, hot), note, ar, er);
        end
    endtask

    // drive at negedge, one rising edge, check at next negedge
    task automatic apply(input logic [2:0] c, input logic [1:0] ps, input logic hc,
                         input logic [1:0] hl, input string note);
        ctl_mode = c; port_sel = ps; hook_core = hc; hook_line = hl;
        @(negedge clk);
        check_all(note);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int unsigned r;
        r = $urandom(32'h5EED_1234);
        // R9: reset state
        repeat (3) @(negedge clk);
        ctl_mode = 3'b110; port_sel = 2'b11; hook_core = 1'b1; hook_line = 2'b11;
        @(negedge clk);
        checks++;
        if ({core_mode, port_term, sum_det_oe, line_det_oe} !== 10'd0) begin
            errors++;
            $display("FAIL R9 reset outputs actual=%b expected=0",
                     {core_mode, port_term, sum_det_oe, line_det_oe});
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 first edge after reset");

        // directed: R2 power down, nothing selected
        apply(3'b000, 2'b00, 1'b1, 2'b11, "pd none");
        apply(3'b100, 2'b00, 1'b0, 2'b11, "pd none C=1");
        // R3/R4: one detector at a time
        apply(3'b000, 2'b01, 1'b0, 2'b01, "pd p1 hook1");
        apply(3'b000, 2'b01, 1'b0, 2'b10, "pd p1 hook2 masked");
        apply(3'b000, 2'b10, 1'b0, 2'b10, "pd p2 hook2");
        apply(3'b000, 2'b11, 1'b1, 2'b00, "pd both no hook, core ignored");
        apply(3'b000, 2'b11, 1'b0, 2'b11, "pd both hooks");
        // R5/R6 active
        apply(3'b010, 2'b01, 1'b1, 2'b11, "active p1");
        apply(3'b110, 2'b10, 1'b1, 2'b00, "active rev p2");
        apply(3'b011, 2'b00, 1'b1, 2'b11, "active mtr no port R6");
        apply(3'b111, 2'b11, 1'b0, 2'b11, "mtr rev both");
        // R10 ring phase toggling
        for (int k = 0; k < 4; k++)
            apply({k[0], 2'b01}, 2'b11, 1'b0, 2'b00, "ring toggle R10");
        apply(3'b001, 2'b00, 1'b1, 2'b00, "ring no port R6");

        // random sweep
        for (int n = 0; n < 400; n++) begin
            r = $urandom;
            apply(r[2:0], r[4:3], r[5], r[7:6], "random");
        end

        // R7/R8 thermal sequences
        for (int rep = 0; rep < 3; rep++) begin
            r = $urandom;
            ctl_mode = 3'b010; port_sel = 2'b01; hook_core = 1'b1; hook_line = 2'b00;
            therm_alarm = 1'b1;
            @(negedge clk); @(negedge clk);
            check_all("R7 not yet forced after two edges");
            hot = 1'b1;
            @(negedge clk);
            check_all("R7 forced on third edge");
            for (int k = 0; k < 5; k++) begin
                r = $urandom;
                apply(r[2:0], r[4:3], r[5], r[7:6], "R7 held under random command");
            end
            ctl_mode = 3'b000; port_sel = 2'b11; hook_line = 2'b10;
            therm_alarm = 1'b0;
            @(negedge clk); @(negedge clk);
            check_all("R8 still forced after two edges");
            hot = 1'b0;
            @(negedge clk);
            check_all("R8 restored on third edge");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule